// File: doc/BRIEF.md
# Bayer Per-Color Gain and Offset Stage

This block sits in a raw camera pixel stream and scales each Bayer sample by a gain chosen from its color. It finds the color without any side information. It counts pixel parity within a line and line parity within a frame. It combines these with the field identifier to pick one of eight 2-bit codes from a programmable pattern word. Each code names one of four fixed-point gain registers.

After the gain, one offset that is shared by all colors can be added, and the result is clamped to the pixel range. The block drives three copies of the result: a memory path, a pipeline path and a statistics path. Each copy has its own switch for the gain and its own switch for the offset, so one consumer can see corrected data while another sees raw data. Configuration is loaded through a simple write port, and is normally changed while the stream is idle.

Top module: `bayer_gain_offset`

## Requirements
- R1: After reset the pattern word is 0x1E1E, all four gains hold 1.0 (0x200), the offset is 0 and all six enables are off, so every output path carries the input pixel unchanged; during reset `outValid`, `outSol`, `outSof` and all three pixel outputs are 0.
- R2: A pixel presented with `pixValid` high appears on the three pixel outputs two clock cycles later. `outValid` is `pixValid` delayed by two cycles. `outSol` and `outSof` are the input markers qualified by `pixValid` and delayed by two cycles.
- R3: Pixel parity is odd for a valid pixel that carries `pixSol` or `pixSof`. It alternates on each later valid pixel of the line. Cycles with `pixValid` low change nothing.
- R4: Line parity is odd on a valid pixel that carries `pixSof`. It flips on each later valid pixel that carries `pixSol` without `pixSof`.
- R5: The color code is bits [2k+1:2k] of the pattern word, where k = 4*field + 2*(even line) + (even pixel). Field 0 therefore uses the low byte and field 1 the high byte.
- R6: Gain codes 0, 1, 2 and 3 select gain registers at write addresses 1, 2, 3 and 4. Each gain is 12 bits unsigned: 3 integer bits above 9 fractional bits. With the gain enabled, the result is (pixel * gain) >> 9.
- R7: Write address 5 holds a 10-bit offset shared by all colors. With the offset enabled, it is added after the gain stage, or to the raw pixel if the gain is disabled.
- R8: Any result above 4095 is clamped to 4095.
- R9: Write address 6 holds six enables. Bits [0], [1] and [2] turn on the gain for the memory, pipeline and statistics paths. Bits [3], [4] and [5] turn on the offset for the same paths. A disabled stage passes its input through.
- R10: Write address 0 holds the pattern word. A write to address 7 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 3 | Configuration register address |
| cfgWrData | input | 16 | Configuration write data |
| pixValid | input | 1 | Input pixel qualifier |
| pixSol | input | 1 | First pixel of a line |
| pixSof | input | 1 | First pixel of a frame |
| pixField | input | 1 | Field identifier |
| pixData | input | 12 | Raw input pixel |
| outValid | output | 1 | Output pixel qualifier |
| outSol | output | 1 | Delayed start-of-line marker |
| outSof | output | 1 | Delayed start-of-frame marker |
| memPix | output | 12 | Memory path pixel |
| pipePix | output | 12 | Pipeline path pixel |
| statPix | output | 12 | Statistics path pixel |

## Verification
Every pixel result and every marker is due exactly two clock cycles after its input is driven. The bench keeps its expected values in a two-entry delay line. At each falling edge it compares the outputs with the entry driven two falling edges earlier, and only then drives the next input. A configuration write takes effect for the first pixel driven after it. The bench updates its model at the write, and it never drives a pixel in the same cycle as a write.

// File: rtl/bgo_pkg.sv
package bgo_pkg;
  localparam int NUM_PATHS = 3;
  localparam int NUM_CODES = 4;

  typedef struct packed {
    logic       valid;
    logic       sol;
    logic       sof;
    logic [1:0] code;
  } bgo_strobe_t;

  typedef struct packed {
    logic [NUM_PATHS-1:0] ofsEn;
    logic [NUM_PATHS-1:0] gainEn;
  } bgo_enable_t;
endpackage

// File: rtl/bgo_ctrl.sv
module bgo_ctrl
  import bgo_pkg::*;
#(
  parameter int PIX_W    = 12,
  parameter int GAIN_W   = 12,
  parameter int FRAC_W   = 9,
  parameter int OFS_W    = 10,
  parameter int CFG_W    = 16,
  parameter int ADDR_W   = 3,
  parameter logic [15:0] DEF_PAT = 16'h1E1E
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             cfgWrEn,
  input  logic [ADDR_W-1:0]                cfgAddr,
  input  logic [CFG_W-1:0]                 cfgWrData,
  input  logic                             pixValid,
  input  logic                             pixSol,
  input  logic                             pixSof,
  input  logic                             pixField,
  input  logic [PIX_W-1:0]                 pixData,
  output bgo_strobe_t                      stb,
  output logic [PIX_W-1:0]                 s1Pix,
  output logic [NUM_CODES-1:0][GAIN_W-1:0] gainTab,
  output logic [OFS_W-1:0]                 ofsVal,
  output bgo_enable_t                      en
);
  localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(1) << FRAC_W;

  logic [15:0] patReg;
  logic        pixOddReg, lineOddReg;
  logic        pixOddNow, lineOddNow;
  logic [2:0]  slot;
  logic [1:0]  codeNow;

  // parity of the pixel being presented now
  always_comb begin
    pixOddNow  = (pixSol || pixSof) ? 1'b1 : pixOddReg;
    lineOddNow = pixSof ? 1'b1 : (pixSol ? ~lineOddReg : lineOddReg);
    slot       = {pixField, ~lineOddNow, ~pixOddNow};
    codeNow    = patReg[{slot, 1'b0} +: 2];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixOddReg  <= 1'b1;
      lineOddReg <= 1'b1;
    end else if (pixValid) begin
      pixOddReg  <= ~pixOddNow;
      lineOddReg <= lineOddNow;
    end
  end

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      patReg  <= DEF_PAT;
      gainTab <= {NUM_CODES{UNITY}};
      ofsVal  <= '0;
      en      <= '0;
    end else if (cfgWrEn) begin
      case (cfgAddr)
        3'd0:                patReg <= cfgWrData[15:0];
        3'd1, 3'd2, 3'd3, 3'd4:
          gainTab[2'(cfgAddr - 3'd1)] <= cfgWrData[GAIN_W-1:0];
        3'd5:                ofsVal <= cfgWrData[OFS_W-1:0];
        3'd6:                en     <= bgo_enable_t'(cfgWrData[2*NUM_PATHS-1:0]);
        default: ;
      endcase
    end
  end

  // stage 1: capture pixel and its color code
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stb   <= '0;
      s1Pix <= '0;
    end else begin
      stb.valid <= pixValid;
      stb.sol   <= pixValid & pixSol;
      stb.sof   <= pixValid & pixSof;
      stb.code  <= codeNow;
      s1Pix     <= pixData;
    end
  end

  // R5: first pixel of a field-0 frame takes the lowest code of the pattern
  p_first_code_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && pixSof && !pixField && !cfgWrEn) |=> (stb.code == $past(patReg[1:0])));
endmodule

// File: rtl/bgo_datapath.sv
module bgo_datapath
  import bgo_pkg::*;
#(
  parameter int PIX_W  = 12,
  parameter int GAIN_W = 12,
  parameter int FRAC_W = 9,
  parameter int OFS_W  = 10
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  bgo_strobe_t                         stb,
  input  logic [PIX_W-1:0]                    s1Pix,
  input  logic [NUM_CODES-1:0][GAIN_W-1:0]    gainTab,
  input  logic [OFS_W-1:0]                    ofsVal,
  input  bgo_enable_t                         en,
  output logic                                outValid,
  output logic                                outSol,
  output logic                                outSof,
  output logic [NUM_PATHS-1:0][PIX_W-1:0]     pathPix
);
  localparam int PROD_W = PIX_W + GAIN_W;
  localparam int SCL_W  = PROD_W - FRAC_W;
  localparam int SUM_W  = SCL_W + 1;
  localparam logic [SUM_W-1:0] PIX_MAX = SUM_W'((1 << PIX_W) - 1);

  logic [PROD_W-1:0] product;
  logic [SCL_W-1:0]  scaled;

  // one multiplier shared by all paths
  always_comb begin
    product = PROD_W'(s1Pix) * PROD_W'(gainTab[stb.code]);
    scaled  = product[PROD_W-1:FRAC_W];
  end

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    logic [SCL_W-1:0] gainSel;
    logic [SUM_W-1:0] sum;
    logic [PIX_W-1:0] clamped;

    always_comb begin
      gainSel = en.gainEn[p] ? scaled : SCL_W'(s1Pix);
      sum     = SUM_W'(gainSel) + (en.ofsEn[p] ? SUM_W'(ofsVal) : '0);
      clamped = (sum > PIX_MAX) ? PIX_MAX[PIX_W-1:0] : sum[PIX_W-1:0];
    end

    always_ff @(posedge clk) begin
      if (!rstN) pathPix[p] <= '0;
      else       pathPix[p] <= clamped;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outSol   <= 1'b0;
      outSof   <= 1'b0;
    end else begin
      outValid <= stb.valid;
      outSol   <= stb.sol;
      outSof   <= stb.sof;
    end
  end

  // R9: memory path with both stages off reproduces the captured pixel
  p_bypass_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.valid && !en.gainEn[0] && !en.ofsEn[0]) |=> (pathPix[0] == $past(s1Pix)));

  // R7: offset alone never lowers the pipeline pixel
  p_offset_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.valid && !en.gainEn[1] && en.ofsEn[1]) |=> (pathPix[1] >= $past(s1Pix)));
endmodule

// File: rtl/bayer_gain_offset.sv
module bayer_gain_offset
  import bgo_pkg::*;
#(
  parameter int PIX_W  = 12,
  parameter int GAIN_W = 12,
  parameter int FRAC_W = 9,
  parameter int OFS_W  = 10,
  parameter int CFG_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [CFG_W-1:0]  cfgWrData,
  input  logic              pixValid,
  input  logic              pixSol,
  input  logic              pixSof,
  input  logic              pixField,
  input  logic [PIX_W-1:0]  pixData,
  output logic              outValid,
  output logic              outSol,
  output logic              outSof,
  output logic [PIX_W-1:0]  memPix,
  output logic [PIX_W-1:0]  pipePix,
  output logic [PIX_W-1:0]  statPix
);
  bgo_strobe_t                         stb;
  bgo_enable_t                         en;
  logic [PIX_W-1:0]                    s1Pix;
  logic [NUM_CODES-1:0][GAIN_W-1:0]    gainTab;
  logic [OFS_W-1:0]                    ofsVal;
  logic [NUM_PATHS-1:0][PIX_W-1:0]     pathPix;

  bgo_ctrl #(
    .PIX_W(PIX_W), .GAIN_W(GAIN_W), .FRAC_W(FRAC_W), .OFS_W(OFS_W),
    .CFG_W(CFG_W), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .pixValid(pixValid), .pixSol(pixSol),
    .pixSof(pixSof), .pixField(pixField), .pixData(pixData),
    .stb(stb), .s1Pix(s1Pix), .gainTab(gainTab), .ofsVal(ofsVal), .en(en)
  );

  bgo_datapath #(
    .PIX_W(PIX_W), .GAIN_W(GAIN_W), .FRAC_W(FRAC_W), .OFS_W(OFS_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .s1Pix(s1Pix), .gainTab(gainTab),
    .ofsVal(ofsVal), .en(en), .outValid(outValid), .outSol(outSol),
    .outSof(outSof), .pathPix(pathPix)
  );

  assign memPix  = pathPix[0];
  assign pipePix = pathPix[1];
  assign statPix = pathPix[2];

  // R2: valid reaches the output two cycles after the input
  p_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    outValid == $past(pixValid, 2));
endmodule

// File: tb/bayer_gain_offset_tb.sv
module bayer_gain_offset_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWrEn;
  logic [2:0]  cfgAddr;
  logic [15:0] cfgWrData;
  logic        pixValid, pixSol, pixSof, pixField;
  logic [11:0] pixData;
  logic        outValid, outSol, outSof;
  logic [11:0] memPix, pipePix, statPix;

  bayer_gain_offset u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .pixValid(pixValid), .pixSol(pixSol),
    .pixSof(pixSof), .pixField(pixField), .pixData(pixData),
    .outValid(outValid), .outSol(outSol), .outSof(outSof),
    .memPix(memPix), .pipePix(pipePix), .statPix(statPix)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic            v;
    logic            sol;
    logic            sof;
    logic [2:0][11:0] px;
  } exp_t;

  int          nVec = 0;
  int          nFail = 0;
  bit          done = 1'b0;
  string       curReq = "R1";
  exp_t        e1, e2;
  logic [15:0] mPat;
  logic [11:0] mGain [4];
  logic [9:0]  mOfs;
  logic [5:0]  mEn;
  logic        mPixOdd, mLineOdd;

  task automatic chk(string req, int act, int expv, string what);
    nVec++;
    if (act != expv) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic logic [11:0] refPath(logic [11:0] pix, logic [1:0] code, int path);
    int t;
    t = pix;
    if (mEn[path])     t = (pix * mGain[code]) >> 9;
    if (mEn[path + 3]) t = t + mOfs;
    if (t > 4095)      t = 4095;
    return 12'(t);
  endfunction

  task automatic modelReset();
    mPat = 16'h1E1E;
    for (int i = 0; i < 4; i++) mGain[i] = 12'h200;
    mOfs = '0; mEn = '0; mPixOdd = 1'b1; mLineOdd = 1'b1;
    e1 = '0; e2 = '0;
  endtask

  // one cycle: check the result due now, then drive the next input
  task automatic step(logic v, logic sol, logic sof, logic fld, logic [11:0] pix,
                      logic we, logic [2:0] addr, logic [15:0] data);
    exp_t ne;
    logic curPix, curLine;
    logic [2:0] slot;
    logic [1:0] code;
    @(negedge clk);
    chk("R2", int'(outValid), int'(e2.v), "outValid");
    chk("R2", int'(outSol), int'(e2.sol), "outSol");
    chk("R2", int'(outSof), int'(e2.sof), "outSof");
    if (e2.v) begin
      chk(curReq, int'(memPix),  int'(e2.px[0]), "memPix");
      chk(curReq, int'(pipePix), int'(e2.px[1]), "pipePix");
      chk(curReq, int'(statPix), int'(e2.px[2]), "statPix");
    end
    e2 = e1;
    pixValid = v; pixSol = sol; pixSof = sof; pixField = fld; pixData = pix;
    cfgWrEn = we; cfgAddr = addr; cfgWrData = data;
    ne = '0;
    ne.v = v; ne.sol = v & sol; ne.sof = v & sof;
    if (v) begin
      curPix  = (sol || sof) ? 1'b1 : mPixOdd;       // R3
      curLine = sof ? 1'b1 : (sol ? ~mLineOdd : mLineOdd);  // R4
      slot    = {fld, ~curLine, ~curPix};            // R5
      code    = mPat[2*slot +: 2];
      for (int p = 0; p < 3; p++) ne.px[p] = refPath(pix, code, p);
      mPixOdd = ~curPix; mLineOdd = curLine;
    end
    e1 = ne;
    if (we) begin  // R10 register map
      case (addr)
        3'd0: mPat = data;
        3'd1, 3'd2, 3'd3, 3'd4: mGain[addr - 3'd1] = data[11:0];
        3'd5: mOfs = data[9:0];
        3'd6: mEn  = data[5:0];
        default: ;
      endcase
    end
  endtask

  task automatic wr(logic [2:0] addr, logic [15:0] data);
    step(1'b0, 1'b0, 1'b0, 1'b0, 12'd0, 1'b1, addr, data);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 1'b0, 12'(i), 1'b0, 3'd0, 16'd0);
  endtask

  task automatic frame(logic fld, int lines, int width, bit gaps, bit fixed, logic [11:0] fpix);
    for (int l = 0; l < lines; l++) begin
      for (int x = 0; x < width; x++) begin
        if (gaps && ($urandom % 4 == 0))
          step(1'b0, 1'b0, 1'b0, fld, 12'($urandom), 1'b0, 3'd0, 16'd0);
        step(1'b1, x == 0, (x == 0) && (l == 0), fld,
             fixed ? fpix : 12'($urandom), 1'b0, 3'd0, 16'd0);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rstN = 1'b0; cfgWrEn = 0; cfgAddr = 0; cfgWrData = 0;
    pixValid = 0; pixSol = 0; pixSof = 0; pixField = 0; pixData = 0;
    modelReset();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", int'(outValid), 0, "outValid in reset");
    chk("R1", int'(outSol | outSof), 0, "markers in reset");
    chk("R1", int'(memPix | pipePix | statPix), 0, "pixels in reset");
    rstN = 1'b1;

    // R1 default pass-through, even with gaps
    curReq = "R1";
    frame(1'b0, 3, 6, 1'b1, 1'b0, 12'd0);

    // R3 R4 R5 R6: distinct gains per code, asymmetric pattern, both fields
    curReq = "R5";
    wr(3'd0, 16'hE41B);
    wr(3'd1, 16'h0100); wr(3'd2, 16'h0200); wr(3'd3, 16'h0300); wr(3'd4, 16'h0400);
    wr(3'd6, 16'h0007);
    frame(1'b0, 4, 5, 1'b1, 1'b0, 12'd0);
    frame(1'b1, 4, 5, 1'b1, 1'b0, 12'd0);
    curReq = "R6";
    frame(1'b0, 2, 4, 1'b0, 1'b1, 12'd1000);

    // R7 offset after gain
    curReq = "R7";
    wr(3'd5, 16'd100); wr(3'd6, 16'h0038);
    frame(1'b1, 2, 5, 1'b0, 1'b0, 12'd0);
    wr(3'd6, 16'h003F);
    frame(1'b0, 2, 5, 1'b0, 1'b0, 12'd0);

    // R8 saturation at top of range
    curReq = "R8";
    for (int c = 1; c <= 4; c++) wr(3'(c), 16'h0FFF);
    wr(3'd5, 16'h03FF);
    frame(1'b0, 2, 4, 1'b0, 1'b1, 12'hFFF);
    frame(1'b0, 1, 4, 1'b0, 1'b1, 12'd600);

    // R9 independent per-path enables
    curReq = "R9";
    wr(3'd1, 16'h0180); wr(3'd2, 16'h0280); wr(3'd5, 16'd37);
    wr(3'd6, 16'h0015);
    frame(1'b1, 2, 6, 1'b1, 1'b0, 12'd0);
    wr(3'd6, 16'h002A);
    frame(1'b0, 2, 6, 1'b1, 1'b0, 12'd0);

    // R10 write to an unused address
    curReq = "R10";
    wr(3'd7, 16'hFFFF);
    frame(1'b0, 2, 6, 1'b0, 1'b0, 12'd0);

    // random configurations
    for (int it = 0; it < 25; it++) begin
      curReq = "R6";
      wr(3'd0, 16'($urandom));
      for (int c = 1; c <= 4; c++) wr(3'(c), 16'($urandom));
      wr(3'd5, 16'($urandom));
      wr(3'd6, 16'($urandom));
      frame(1'($urandom), 1 + ($urandom % 4), 1 + ($urandom % 8), 1'b1, 1'b0, 12'd0);
    end
    idle(3);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end
endmodule